// File: doc/BRIEF.md
# Overcurrent Limit Quantizer and Monitor

This block serves one power rail of a multi-rail buck controller. It takes two overcurrent command words and derives two thresholds from them. Both words use a 31.25 mA code step. The warning threshold keeps that fine resolution. The fault threshold is converted into a setting code for an analog comparator. That comparator only supports a coarse current grid, and the grid depends on the rail type. Any command that falls between comparator steps is rounded up, never down. Commands beyond the rail's top step saturate at the highest setting.

The block also times a current sample at the middle of each low-side conduction interval. At that point the inductor current equals its average value rather than its peak. It measures how long the low-side gate was high in one switching cycle. In the next cycle it raises a sample strobe after half that time. On the strobe cycle it compares the ADC current word against the warning threshold. A fault flag is latched from the comparator's trip output, which is asynchronous to the clock. Both flags stay set until a clear pulse. New commands and the rail type are taken only at low-side turn-on, so a threshold never changes partway through a comparison.

Top module: `ocp_limit_monitor`

## Requirements
- R1: Commands and rail type are captured only on a clock where `ls_gate` is high and was low on the clock before (low-side turn-on). `cmp_code` changes only after such a clock and holds its value otherwise.
- R2: With `rail_sel` = 0 (2 A rail), `cmp_code` equals ceil(`fault_cmd`/8). The valid codes are 0 to 16.
- R3: With `rail_sel` = 1 (4 A rail), `cmp_code` equals ceil(`fault_cmd`/16). The valid codes are 0 to 16.
- R4: With `rail_sel` = 2 or 3 (combined dual-phase rail), `cmp_code` equals ceil(`fault_cmd`/16). The valid codes are 0 to 32.
- R5: A fault command above the selected rail's top step gives the rail's maximum code (16, 16 or 32).
- R6: A low-side interval that held `ls_gate` high for W clocks sets the strobe point H = floor(W/2) for the next interval. Counting that interval's first high clock as 1, `samp_strobe` is high for exactly one cycle after the H-th high clock.
- R7: No strobe is produced in an interval whose previous interval was shorter than 2 clocks. This includes the first interval after reset.
- R8: On the strobe clock, `warn_flag` sets if `adc_cur` >= the warning command word. The comparison is at full 9-bit resolution. It uses the command captured at the current interval's turn-on, even when the strobe falls on the turn-on clock itself.
- R9: `comp_trip` passes through a two-stage synchronizer. After the clock that first samples it high, `fault_flag` is high two clocks later.
- R10: Both flags stay set until `flag_clr` is high. If a set condition and `flag_clr` occur in the same cycle, the set wins.
- R11: Synchronous reset clears `cmp_code`, `samp_strobe`, both flags, the stored warning threshold and the previous-interval length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ls_gate | input | 1 | Low-side switch gate drive, high during conduction |
| rail_sel | input | 2 | Rail type: 0 = 2 A, 1 = 4 A, 2/3 = combined |
| warn_cmd | input | 9 | Warning limit command, 31.25 mA per code |
| fault_cmd | input | 9 | Fault limit command, 31.25 mA per code |
| adc_cur | input | 9 | ADC output current, 31.25 mA per code |
| comp_trip | input | 1 | Asynchronous trip output of the fault comparator |
| flag_clr | input | 1 | Clears both latched flags |
| cmp_code | output | 6 | Comparator setting code (steps of the rail's grid) |
| samp_strobe | output | 1 | One-cycle pulse at mid low-side conduction |
| warn_flag | output | 1 | Latched warning flag |
| fault_flag | output | 1 | Latched fault flag |

## Verification
The assertions check on every cycle that a captured command never produces a code below the command unless saturated, that the code stays in range, and that the code holds between turn-on events. They also check that the strobe is single-cycle and falls inside a conduction interval, and that each flag rises only after its cause and holds until cleared. Only the bench scenarios show the exact strobe position for even, odd and short previous intervals, the exact code values on each rail, and the two-clock trip latency. The same applies to the use of a fresh warning command when the strobe falls on the turn-on clock.

// File: rtl/ocp_pkg.sv
package ocp_pkg;
  typedef enum logic [1:0] {
    RAIL_SMALL    = 2'b00,
    RAIL_MED      = 2'b01,
    RAIL_COMB     = 2'b10,
    RAIL_COMB_ALT = 2'b11
  } rail_e;
endpackage

// File: rtl/ocp_fault_quant.sv
module ocp_fault_quant
  import ocp_pkg::*;
#(
  parameter int CMD_W     = 9,
  parameter int CODE_W    = 6,
  parameter int SMALL_SH  = 3,
  parameter int LARGE_SH  = 4,
  parameter int SMALL_MAX = 16,
  parameter int MED_MAX   = 16,
  parameter int COMB_MAX  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [1:0]        rail_i,
  input  logic [CMD_W-1:0]  cmd_i,
  output logic [CODE_W-1:0] code_o
);
  localparam int SW = CMD_W + 1;
  localparam logic [SW-1:0] SMALL_ADD = SW'((1 << SMALL_SH) - 1);
  localparam logic [SW-1:0] LARGE_ADD = SW'((1 << LARGE_SH) - 1);

  rail_e          rail;
  logic [SW-1:0]  ceil_s, ceil_l, ceil_sel, max_sel;
  logic [2:0]     sh_sel;
  logic [CODE_W-1:0] code_nxt;

  assign rail   = rail_e'(rail_i);
  assign ceil_s = (SW'(cmd_i) + SMALL_ADD) >> SMALL_SH;
  assign ceil_l = (SW'(cmd_i) + LARGE_ADD) >> LARGE_SH;

  always_comb begin
    case (rail)
      RAIL_SMALL: begin ceil_sel = ceil_s; max_sel = SW'(SMALL_MAX); sh_sel = 3'(SMALL_SH); end
      RAIL_MED:   begin ceil_sel = ceil_l; max_sel = SW'(MED_MAX);   sh_sel = 3'(LARGE_SH); end
      default:    begin ceil_sel = ceil_l; max_sel = SW'(COMB_MAX);  sh_sel = 3'(LARGE_SH); end
    endcase
    code_nxt = (ceil_sel > max_sel) ? CODE_W'(max_sel) : CODE_W'(ceil_sel);
  end

  always_ff @(posedge clk) begin
    if (rst)         code_o <= '0;
    else if (load_i) code_o <= code_nxt;
  end

  // R2 R3 R5: code never sits below the command unless saturated
  assert_round_up_R2: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (SW'(code_o) == $past(max_sel)) ||
               ((SW'(code_o) << $past(sh_sel)) >= $past(SW'(cmd_i))));
  assert_code_range_R4: assert property (@(posedge clk) disable iff (rst)
    SW'(code_o) <= SW'(COMB_MAX));
endmodule

// File: rtl/ocp_mid_timer.sv
module ocp_mid_timer #(
  parameter int CNT_W = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic gate_i,
  output logic rise_o,
  output logic hit_o,
  output logic strobe_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO     = CNT_W'(2);

  logic             g_q, fall;
  logic [CNT_W-1:0] cnt_q, width_q, cnt_nxt, half;

  assign rise_o  = gate_i & ~g_q;
  assign fall    = ~gate_i & g_q;
  assign cnt_nxt = rise_o ? ONE : ((cnt_q == CNT_MAX) ? cnt_q : cnt_q + ONE);
  assign half    = width_q >> 1;
  assign hit_o   = gate_i && (width_q >= TWO) && (cnt_nxt == half);

  always_ff @(posedge clk) begin
    if (rst) begin
      g_q      <= 1'b0;
      cnt_q    <= '0;
      width_q  <= '0;
      strobe_o <= 1'b0;
    end else begin
      g_q      <= gate_i;
      strobe_o <= hit_o;
      if (gate_i) cnt_q <= cnt_nxt;
      if (fall)   width_q <= cnt_q;
    end
  end

  // R6: the strobe is a single pulse inside a conduction interval
  assert_strobe_single_R6: assert property (@(posedge clk) disable iff (rst)
    strobe_o |=> !strobe_o);
  assert_strobe_in_gate_R6: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> $past(gate_i));
endmodule

// File: rtl/ocp_flag_latch.sv
module ocp_flag_latch #(
  parameter int CMD_W   = 9,
  parameter int SYNC_ST = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             hit_i,
  input  logic [CMD_W-1:0] warn_cmd_i,
  input  logic [CMD_W-1:0] adc_i,
  input  logic             trip_i,
  input  logic             clr_i,
  output logic             warn_o,
  output logic             fault_o
);
  logic [CMD_W-1:0]   warn_thr_q, eff_thr;
  logic [SYNC_ST-1:0] sync_q;
  logic               trip_s;

  generate
    if (SYNC_ST == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= trip_i;
      end
    end else begin : g_syncn
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_ST-2:0], trip_i};
      end
    end
  endgenerate

  assign trip_s  = sync_q[SYNC_ST-1];
  assign eff_thr = load_i ? warn_cmd_i : warn_thr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_thr_q <= '0;
      warn_o     <= 1'b0;
      fault_o    <= 1'b0;
    end else begin
      if (load_i) warn_thr_q <= warn_cmd_i;
      warn_o  <= (warn_o & ~clr_i) | (hit_i & (adc_i >= eff_thr));
      fault_o <= (fault_o & ~clr_i) | trip_s;
    end
  end

  assert_warn_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (warn_o && !clr_i) |=> warn_o);
  assert_fault_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (fault_o && !clr_i) |=> fault_o);
  assert_warn_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(warn_o) |-> $past(hit_i));
  assert_fault_cause_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_o) |-> $past(trip_s));
endmodule

// File: rtl/ocp_limit_monitor.sv
module ocp_limit_monitor #(
  parameter int CMD_W   = 9,
  parameter int CODE_W  = 6,
  parameter int CNT_W   = 12,
  parameter int SYNC_ST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ls_gate,
  input  logic [1:0]        rail_sel,
  input  logic [CMD_W-1:0]  warn_cmd,
  input  logic [CMD_W-1:0]  fault_cmd,
  input  logic [CMD_W-1:0]  adc_cur,
  input  logic              comp_trip,
  input  logic              flag_clr,
  output logic [CODE_W-1:0] cmp_code,
  output logic              samp_strobe,
  output logic              warn_flag,
  output logic              fault_flag
);
  logic gate_rise, sample_hit;

  ocp_mid_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst(rst), .gate_i(ls_gate),
    .rise_o(gate_rise), .hit_o(sample_hit), .strobe_o(samp_strobe)
  );

  ocp_fault_quant #(.CMD_W(CMD_W), .CODE_W(CODE_W)) quant_i (
    .clk(clk), .rst(rst), .load_i(gate_rise), .rail_i(rail_sel),
    .cmd_i(fault_cmd), .code_o(cmp_code)
  );

  ocp_flag_latch #(.CMD_W(CMD_W), .SYNC_ST(SYNC_ST)) flags_i (
    .clk(clk), .rst(rst), .load_i(gate_rise), .hit_i(sample_hit),
    .warn_cmd_i(warn_cmd), .adc_i(adc_cur), .trip_i(comp_trip),
    .clr_i(flag_clr), .warn_o(warn_flag), .fault_o(fault_flag)
  );

  // R1: the comparator code only moves at a low-side turn-on
  assert_code_stable_R1: assert property (@(posedge clk) disable iff (rst)
    !gate_rise |=> $stable(cmp_code));
endmodule

// File: tb/ocp_limit_monitor_tb_top.sv
module ocp_limit_monitor_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ls_gate = 1'b0;
  logic [1:0] rail_sel = '0;
  logic [8:0] warn_cmd = '0, fault_cmd = '0, adc_cur = '0;
  logic comp_trip = 1'b0, flag_clr = 1'b0;
  logic [5:0] cmp_code;
  logic samp_strobe, warn_flag, fault_flag;

  int tests = 0, fails = 0;
  int sc, si;

  always #2.5 clk = ~clk;

  ocp_limit_monitor dut_i (
    .clk(clk), .rst(rst), .ls_gate(ls_gate), .rail_sel(rail_sel),
    .warn_cmd(warn_cmd), .fault_cmd(fault_cmd), .adc_cur(adc_cur),
    .comp_trip(comp_trip), .flag_clr(flag_clr), .cmp_code(cmp_code),
    .samp_strobe(samp_strobe), .warn_flag(warn_flag), .fault_flag(fault_flag)
  );

  typedef struct packed {
    logic [1:0] rail;
    logic [8:0] fcmd;
    logic [8:0] wcmd;
    logic [8:0] adc;
    logic [5:0] code;
    logic       warn;
    logic       sat;
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{2'd0, 9'd0,   9'd100, 9'd99,  6'd0,  1'b0, 1'b0},
    '{2'd0, 9'd1,   9'd100, 9'd100, 6'd1,  1'b1, 1'b0},
    '{2'd0, 9'd8,   9'd100, 9'd101, 6'd1,  1'b1, 1'b0},
    '{2'd0, 9'd9,   9'd255, 9'd10,  6'd2,  1'b0, 1'b0},
    '{2'd0, 9'd128, 9'd0,   9'd0,   6'd16, 1'b1, 1'b0},
    '{2'd0, 9'd129, 9'd511, 9'd510, 6'd16, 1'b0, 1'b1},
    '{2'd1, 9'd16,  9'd37,  9'd36,  6'd1,  1'b0, 1'b0},
    '{2'd1, 9'd17,  9'd37,  9'd37,  6'd2,  1'b1, 1'b0},
    '{2'd1, 9'd256, 9'd0,   9'd5,   6'd16, 1'b1, 1'b0},
    '{2'd1, 9'd300, 9'd200, 9'd300, 6'd16, 1'b1, 1'b1},
    '{2'd2, 9'd255, 9'd1,   9'd0,   6'd16, 1'b0, 1'b0},
    '{2'd2, 9'd257, 9'd400, 9'd450, 6'd17, 1'b1, 1'b0},
    '{2'd3, 9'd511, 9'd511, 9'd511, 6'd32, 1'b1, 1'b0},
    '{2'd2, 9'd496, 9'd0,   9'd0,   6'd31, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive a low-side interval: hi clocks high, lo clocks low; records strobes
  task automatic pulse(input int hi, input int lo);
    sc = 0; si = -1;
    ls_gate = 1'b1;
    for (int i = 1; i <= hi; i++) begin
      @(negedge clk);
      if (samp_strobe) begin sc++; si = i; end
    end
    ls_gate = 1'b0;
    for (int i = 0; i < lo; i++) begin
      @(negedge clk);
      if (samp_strobe) sc++;
    end
  endtask

  task automatic clear_flags();
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 50000; c++) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    string tag;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 code", cmp_code, 0);
    chk("R11 strobe", samp_strobe, 0);
    chk("R11 warn", warn_flag, 0);
    chk("R11 fault", fault_flag, 0);

    // R7: first interval after reset has no history
    warn_cmd = 9'd0;
    pulse(8, 4);
    chk("R7 first interval strobes", sc, 0);
    chk("R7 warn untouched", warn_flag, 0);

    foreach (VECS[k]) begin
      clear_flags();
      rail_sel  = VECS[k].rail;
      fault_cmd = VECS[k].fcmd;
      warn_cmd  = VECS[k].wcmd;
      adc_cur   = VECS[k].adc;
      pulse(8, 4);
      if (VECS[k].sat)          tag = "R5";
      else if (VECS[k].rail == 0) tag = "R2";
      else if (VECS[k].rail == 1) tag = "R3";
      else                        tag = "R4";
      chk({tag, " code"}, cmp_code, VECS[k].code);
      chk("R8 warn", warn_flag, VECS[k].warn);
      chk("R6 strobe count", sc, 1);
      chk("R6 strobe position", si, 4);
    end

    // R1: command change mid-interval is ignored until next turn-on
    rail_sel = 2'd0; fault_cmd = 9'd24; warn_cmd = 9'd511; adc_cur = 9'd0;
    pulse(8, 4);
    chk("R1 code after load", cmp_code, 3);
    ls_gate = 1'b1;
    repeat (3) @(negedge clk);
    fault_cmd = 9'd64;
    repeat (5) @(negedge clk);
    ls_gate = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 code held", cmp_code, 3);
    pulse(8, 4);
    chk("R1 code next turn-on", cmp_code, 8);

    // R7: short previous interval suppresses the strobe
    pulse(1, 4);
    pulse(8, 4);
    chk("R7 after 1-clock interval", sc, 0);
    pulse(8, 4);
    chk("R6 restored count", sc, 1);
    chk("R6 restored position", si, 4);

    // R6: odd previous length rounds down
    pulse(7, 4);
    pulse(10, 4);
    chk("R6 odd width position", si, 3);

    // R8: strobe on the turn-on clock uses the freshly captured command
    clear_flags();
    warn_cmd = 9'd511; adc_cur = 9'd60;
    pulse(2, 4);
    chk("R8 high threshold no warn", warn_flag, 0);
    warn_cmd = 9'd50;
    pulse(5, 4);
    chk("R6 half=1 position", si, 1);
    chk("R8 fresh threshold warn", warn_flag, 1);

    // R10: warning latched while samples fall below threshold
    adc_cur = 9'd0;
    pulse(5, 4);
    chk("R10 warn held", warn_flag, 1);
    clear_flags();
    chk("R10 warn cleared", warn_flag, 0);

    // R9: synchronizer latency
    comp_trip = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R9 fault not yet", fault_flag, 0);
    @(negedge clk);
    chk("R9 fault set", fault_flag, 1);
    // R10: set wins over clear while trip stays high
    clear_flags();
    chk("R10 set wins", fault_flag, 1);
    comp_trip = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10 fault held", fault_flag, 1);
    clear_flags();
    chk("R10 fault cleared", fault_flag, 0);

    finish_run();
  end
endmodule